// File: doc/BRIEF.md
# Parallel Camera-Bus Frame Emulator

This block stands in for an image sensor on an 8-bit parallel camera port, so that a host's capture hardware can receive arbitrary raw data as if it were video. It divides a fast system clock down to a pixel clock and drives a frame marker, a line marker and an 8-bit data bus. The payload is an incrementing counter, so the receiver can detect lost or reordered samples.

All bus outputs move at the instant the pixel clock falls, so the receiver samples them on the rising edge. The receiver is assumed to work with a gated clock, which means data is qualified only by the sync lines and no codes are embedded in the stream. A frame marker is always driven on its own pin. A run-time input chooses how the line marker behaves: it can give one short pulse ahead of every line, or it can stay high across the whole frame. The frame geometry, the blanking lengths and the pixel width (one or two bytes) are parameters. After a single start request, frames follow one another without a break.

Top module: `cam_frame_emu`

## Requirements
- R1: `pclk_o` has a period of 2×HALF system clocks, with HALF = SYS_HZ/(2·PCLK_HZ). It spends HALF cycles high and HALF cycles low.
- R2: `vsync_o`, `hsync_o` and `data_o` change only in the system-clock cycle in which `pclk_o` falls.
- R3: During and after reset, until a start request has been taken, `vsync_o`, `hsync_o`, `data_o` and `frame_done_o` all stay 0.
- R4: Once started, every frame consists of VBLANK pixel clocks with `vsync_o` low, followed by LINES lines. Each line is HBLANK blanking clocks and then PIX_PER_LINE·BYTES_PER_PIX data clocks, and `vsync_o` is high throughout the lines. Frames repeat with no gap.
- R5: Line-pulse mode (`hold_mode_i`=0): `hsync_o` is high for exactly one pixel clock per line, the last blanking clock before that line's data. It is low at all other times.
- R6: Frame-hold mode (`hold_mode_i`=1): `hsync_o` is high from the first data byte of the frame to the last one, and stays high through the blanking between lines. It is low before the first line and during frame blanking.
- R7: `hold_mode_i` is sampled only when a frame's blanking period begins. A change made while a frame is in progress takes effect from the next frame on.
- R8: With BYTES_PER_PIX=2, data byte k of a frame, counted from 0 across the lines, carries pixel value p = k/2 as a 16-bit number. The most significant byte comes first. p restarts at 0 in every frame.
- R9: With BYTES_PER_PIX=1, data byte k of a frame carries k modulo 256, so the 8-bit counter wraps from 255 to 0 inside the frame.
- R10: `data_o` is 0 in every blanking clock, whether between lines or between frames.
- R11: `frame_done_o` is high for exactly one system clock after the last byte of each frame. That cycle is the one in which `vsync_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; begins continuous frames |
| hold_mode_i | input | 1 | 0 = line-pulse, 1 = frame-hold line marker |
| pclk_o | output | 1 | Divided pixel clock |
| vsync_o | output | 1 | Frame marker, high while lines are sent |
| hsync_o | output | 1 | Line marker |
| data_o | output | 8 | Payload byte |
| frame_done_o | output | 1 | One-cycle pulse after the last byte of a frame |

## Verification
Every bus output changes in the system cycle in which `pclk_o` falls. The bench therefore reads the bus 1 ns after each `pclk_o` rise, when the value has been stable for HALF cycles, and indexes its expected frame by the count of rising edges since `vsync_o` was first seen high. `frame_done_o` comes from a register set on the falling edge that ends the last byte. It is counted at system-clock falling edges and compared on the first sample that shows `vsync_o` low again. A mode change made in the middle of a frame is checked against the old mode for that frame and against the new mode for the frame after it.

// File: rtl/cam_emu_pkg.sv
package cam_emu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_VBL  = 2'd1,
    PH_HBL  = 2'd2,
    PH_ACT  = 2'd3
  } phase_t;

  // system clocks per half pixel period
  function automatic int half_period(longint sys_hz, longint pclk_hz);
    longint h;
    h = sys_hz / (2 * pclk_hz);
    return (h < 1) ? 1 : int'(h);
  endfunction

  // bits needed to count 0..n-1
  function automatic int cnt_width(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // byte sel (0 = first sent) of a bpp-byte counter value, MSB first
  function automatic logic [7:0] pick_byte(logic [15:0] val, int sel, int bpp);
    int sh;
    sh = 8 * (bpp - 1 - sel);
    return 8'(val >> sh);
  endfunction

endpackage

// File: rtl/cam_pclk_div.sv
module cam_pclk_div #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic pclk_o,
  output logic fall_o
);
  import cam_emu_pkg::*;

  localparam int DW = cnt_width(HALF);

  logic [DW-1:0] div_q;
  logic          pclk_q;
  logic          wrap_w;

  assign wrap_w = (div_q == DW'(HALF - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q  <= '0;
      pclk_q <= 1'b0;
    end else if (wrap_w) begin
      div_q  <= '0;
      pclk_q <= ~pclk_q;
    end else begin
      div_q  <= div_q + DW'(1);
    end
  end

  assign pclk_o = pclk_q;
  // strobe: pclk falls at the coming edge
  assign fall_o = wrap_w & pclk_q;

endmodule

// File: rtl/cam_frame_seq.sv
module cam_frame_seq #(
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 32,
  parameter int HBLANK     = 4,
  parameter int VBLANK     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  fall_i,
  input  logic                  start_i,
  input  logic                  hold_mode_i,
  output cam_emu_pkg::phase_t   phase_o,
  output logic                  blk_last_o,
  output logic                  first_line_o,
  output logic                  mode_o,
  output logic                  byte_adv_o,
  output logic                  frame_rst_o,
  output logic                  done_o
);
  import cam_emu_pkg::*;

  localparam int CW = cnt_width(max3(VBLANK, HBLANK, LINE_BYTES));
  localparam int LW = cnt_width(LINES);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] line_q;
  logic          armed_q;
  logic          mode_q;
  logic          done_q;

  logic go_w, last_vbl_w, last_hbl_w, last_byte_w, last_line_w, frame_end_w;

  assign go_w        = armed_q | start_i;
  assign last_vbl_w  = (cnt_q == CW'(VBLANK - 1));
  assign last_hbl_w  = (cnt_q == CW'(HBLANK - 1));
  assign last_byte_w = (cnt_q == CW'(LINE_BYTES - 1));
  assign last_line_w = (line_q == LW'(LINES - 1));
  assign frame_end_w = (phase_q == PH_ACT) & last_byte_w & last_line_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      line_q  <= '0;
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) armed_q <= 1'b1;
      if (fall_i) begin
        unique case (phase_q)
          PH_IDLE: if (go_w) begin
            phase_q <= PH_VBL;
            cnt_q   <= '0;
            mode_q  <= hold_mode_i;
          end
          PH_VBL: if (last_vbl_w) begin
            phase_q <= PH_HBL;
            cnt_q   <= '0;
            line_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
          PH_HBL: if (last_hbl_w) begin
            phase_q <= PH_ACT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
          PH_ACT: if (last_byte_w) begin
            cnt_q <= '0;
            if (last_line_w) begin
              phase_q <= PH_VBL;
              mode_q  <= hold_mode_i;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_HBL;
              line_q  <= line_q + LW'(1);
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o      = phase_q;
  assign blk_last_o   = (phase_q == PH_HBL) & last_hbl_w;
  assign first_line_o = (line_q == '0);
  assign mode_o       = mode_q;
  assign byte_adv_o   = fall_i & (phase_q == PH_ACT);
  assign frame_rst_o  = fall_i & (((phase_q == PH_IDLE) & go_w) | frame_end_w);
  assign done_o       = done_q;

endmodule

// File: rtl/cam_payload.sv
module cam_payload #(
  parameter int BYTES_PER_PIX = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       byte_adv_i,
  input  logic       frame_rst_i,
  output logic [7:0] byte_o
);
  import cam_emu_pkg::*;

  localparam int VW = 8 * BYTES_PER_PIX;
  localparam int SW = cnt_width(BYTES_PER_PIX);

  logic [VW-1:0] val_q;
  logic [SW-1:0] sel_q;
  logic          last_sel_w;

  assign last_sel_w = (sel_q == SW'(BYTES_PER_PIX - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || frame_rst_i) begin
      val_q <= '0;
      sel_q <= '0;
    end else if (byte_adv_i) begin
      if (last_sel_w) begin
        sel_q <= '0;
        val_q <= val_q + VW'(1);
      end else begin
        sel_q <= sel_q + SW'(1);
      end
    end
  end

  assign byte_o = pick_byte(16'(val_q), int'(sel_q), BYTES_PER_PIX);

endmodule

// File: rtl/cam_frame_emu.sv
module cam_frame_emu #(
  parameter longint SYS_HZ        = 64_000_000,
  parameter longint PCLK_HZ       = 8_000_000,
  parameter int     PIX_PER_LINE  = 16,
  parameter int     LINES         = 16,
  parameter int     BYTES_PER_PIX = 2,
  parameter int     HBLANK        = 4,
  parameter int     VBLANK        = 8
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       start_i,
  input  logic       hold_mode_i,
  output logic       pclk_o,
  output logic       vsync_o,
  output logic       hsync_o,
  output logic [7:0] data_o,
  output logic       frame_done_o
);
  import cam_emu_pkg::*;

  localparam int HALF       = half_period(SYS_HZ, PCLK_HZ);
  localparam int LINE_BYTES = PIX_PER_LINE * BYTES_PER_PIX;

  // named internal events
  logic       fall_w;
  phase_t     phase_w;
  logic       blk_last_w;
  logic       first_line_w;
  logic       mode_q_w;
  logic       byte_adv_w;
  logic       frame_rst_w;
  logic       act_w;
  logic       hbl_w;
  logic [7:0] byte_w;

  cam_pclk_div #(.HALF(HALF)) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pclk_o (pclk_o),
    .fall_o (fall_w)
  );

  cam_frame_seq #(
    .LINES      (LINES),
    .LINE_BYTES (LINE_BYTES),
    .HBLANK     (HBLANK),
    .VBLANK     (VBLANK)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .fall_i       (fall_w),
    .start_i      (start_i),
    .hold_mode_i  (hold_mode_i),
    .phase_o      (phase_w),
    .blk_last_o   (blk_last_w),
    .first_line_o (first_line_w),
    .mode_o       (mode_q_w),
    .byte_adv_o   (byte_adv_w),
    .frame_rst_o  (frame_rst_w),
    .done_o       (frame_done_o)
  );

  cam_payload #(.BYTES_PER_PIX(BYTES_PER_PIX)) u_pay (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .byte_adv_i  (byte_adv_w),
    .frame_rst_i (frame_rst_w),
    .byte_o      (byte_w)
  );

  assign act_w   = (phase_w == PH_ACT);
  assign hbl_w   = (phase_w == PH_HBL);
  assign vsync_o = act_w | hbl_w;
  assign hsync_o = mode_q_w ? (act_w | (hbl_w & ~first_line_w)) : blk_last_w;
  assign data_o  = act_w ? byte_w : 8'h00;

endmodule

// File: rtl/cam_frame_emu_chk.sv
module cam_frame_emu_chk (
  input logic       clk,
  input logic       rst,
  input logic       pclk,
  input logic       vsync,
  input logic       hsync,
  input logic [7:0] data,
  input logic       done,
  input logic       act,
  input logic       mode_q
);

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$fell(pclk) |-> ($stable(vsync) && $stable(hsync) && $stable(data))); // R2

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !vsync |-> (!hsync && data == 8'h00)); // R10

  AST_BYTES_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    act |-> vsync); // R4

  AST_HOLD_ON_BYTES: assert property (@(posedge clk) disable iff (rst)
    (act && mode_q) |-> hsync); // R6

  AST_PULSE_OFF_BYTES: assert property (@(posedge clk) disable iff (rst)
    (act && !mode_q) |-> !hsync); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (vsync && $past(vsync)) |-> $stable(mode_q)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_AT_VS_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(vsync)); // R11

endmodule

bind cam_frame_emu cam_frame_emu_chk u_chk (
  .clk    (clk_i),
  .rst    (rst_i),
  .pclk   (pclk_o),
  .vsync  (vsync_o),
  .hsync  (hsync_o),
  .data   (data_o),
  .done   (frame_done_o),
  .act    (act_w),
  .mode_q (mode_q_w)
);

// File: tb/cam_frame_emu_bench.sv
`timescale 1ns/1ps
module cam_frame_emu_bench;

  // unit A: 2-byte pixels; unit B: byte samples
  localparam int HALF = 2;
  localparam int A_PIX = 4, A_LINES = 3, A_HB = 2, A_VB = 3;
  localparam int B_PIX = 300, B_LINES = 2, B_HB = 1, B_VB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_a = 1'b0, start_b = 1'b0, hold_a = 1'b0;

  logic pclk_a, vs_a, hs_a, done_a, pclk_b, vs_b, hs_b, done_b;
  logic [7:0] dat_a, dat_b;

  int checks = 0, errors = 0;
  int done_cnt_a = 0, done_cnt_b = 0, r2_err = 0, wide_done = 0;
  bit sel = 1'b0;

  always #4 clk = ~clk;

  cam_frame_emu #(
    .SYS_HZ(32_000_000), .PCLK_HZ(8_000_000), .PIX_PER_LINE(A_PIX),
    .LINES(A_LINES), .BYTES_PER_PIX(2), .HBLANK(A_HB), .VBLANK(A_VB)
  ) u_cam_frame_emu (
    .clk_i(clk), .rst_i(rst), .start_i(start_a), .hold_mode_i(hold_a),
    .pclk_o(pclk_a), .vsync_o(vs_a), .hsync_o(hs_a), .data_o(dat_a),
    .frame_done_o(done_a)
  );

  cam_frame_emu #(
    .SYS_HZ(32_000_000), .PCLK_HZ(8_000_000), .PIX_PER_LINE(B_PIX),
    .LINES(B_LINES), .BYTES_PER_PIX(1), .HBLANK(B_HB), .VBLANK(B_VB)
  ) u_cam_frame_emu_byte (
    .clk_i(clk), .rst_i(rst), .start_i(start_b), .hold_mode_i(1'b1),
    .pclk_o(pclk_b), .vsync_o(vs_b), .hsync_o(hs_b), .data_o(dat_b),
    .frame_done_o(done_b)
  );

  wire       pclk_m = sel ? pclk_b : pclk_a;
  wire       vs_m   = sel ? vs_b : vs_a;
  wire       hs_m   = sel ? hs_b : hs_a;
  wire [7:0] dat_m  = sel ? dat_b : dat_a;

  // monitors at the falling system edge
  logic       mon_ok = 1'b0, pclk_prev = 1'b0, done_prev = 1'b0;
  logic [9:0] bus_prev = '0;
  always @(negedge clk) begin
    if (done_a) done_cnt_a++;
    if (done_b) done_cnt_b++;
    if (done_a && done_prev) wide_done++;
    if (!rst) begin
      if (mon_ok && ({vs_a, hs_a, dat_a} != bus_prev) && !(pclk_prev && !pclk_a))
        r2_err++;
      mon_ok = 1'b1;
    end
    bus_prev  = {vs_a, hs_a, dat_a};
    pclk_prev = pclk_a;
    done_prev = done_a;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rise();
    @(posedge pclk_m);
    #1;
  endtask

  task automatic test_reset_idle();
    int bad;
    repeat (3) @(posedge clk);
    #1;
    chk({vs_a, hs_a, dat_a, done_a} == 0, "R3", "outputs in reset",
        int'({vs_a, hs_a, dat_a, done_a}), 0);
    @(posedge clk); #1 rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      rise();
      if ({vs_a, hs_a, dat_a} != 0 || done_cnt_a != 0) bad++;
    end
    chk(bad == 0, "R3", "idle before start", bad, 0);
  endtask

  task automatic test_pclk();
    int hi, lo;
    hi = 0; lo = 0;
    @(posedge pclk_a);
    do begin @(posedge clk); #1; hi++; end while (pclk_a);
    do begin @(posedge clk); #1; lo++; end while (!pclk_a);
    chk(hi == HALF, "R1", "pclk high cycles", hi, HALF);
    chk(lo == HALF, "R1", "pclk low cycles", lo, HALF);
  endtask

  // capture one frame on the selected unit and compare every sample
  task automatic capture(input int pix, input int lines, input int hb,
                         input int bpp, input bit mode_exp, input bit flip,
                         input string hs_tag);
    int lb, done0, bad_vs, bad_hs, bad_dat, bad_blk;
    int a_hs, e_hs1, a_dat, e_dat1, a_blk, idx, pv, ehs, edat;
    bit first;
    lb = pix * bpp;
    bad_vs = 0; bad_hs = 0; bad_dat = 0; bad_blk = 0;
    a_hs = 0; e_hs1 = 0; a_dat = 0; e_dat1 = 0; a_blk = 0;
    rise();
    while (vs_m !== 1'b0) rise();
    while (vs_m !== 1'b1) rise();
    done0 = sel ? done_cnt_b : done_cnt_a;
    first = 1'b1;
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < hb + lb; p++) begin
        if (!first) rise();
        first = 1'b0;
        if (flip && l == 1 && p == 0) hold_a = ~hold_a;
        if (vs_m !== 1'b1) bad_vs++;
        if (p < hb) begin
          ehs = mode_exp ? int'(l != 0) : int'(p == hb - 1);
          if (dat_m != 8'h00) begin bad_blk++; a_blk = dat_m; end
        end else begin
          ehs = mode_exp ? 1 : 0;
          idx = l * lb + (p - hb);
          pv = idx / bpp;
          if (bpp == 1) edat = pv % 256;
          else if (idx % 2 == 0) edat = (pv / 256) % 256;
          else edat = pv % 256;
          if (int'(dat_m) != edat) begin
            if (bad_dat == 0) begin a_dat = dat_m; e_dat1 = edat; end
            bad_dat++;
          end
        end
        if (int'(hs_m) != ehs) begin
          if (bad_hs == 0) begin a_hs = hs_m; e_hs1 = ehs; end
          bad_hs++;
        end
      end
    end
    rise();
    chk(bad_vs == 0 && vs_m == 1'b0, "R4", "vsync over frame", bad_vs, 0);
    chk(bad_hs == 0, hs_tag, "hsync pattern", a_hs, e_hs1);
    chk(bad_dat == 0, (bpp == 1) ? "R9" : "R8", "payload byte", a_dat, e_dat1);
    chk(bad_blk == 0, "R10", "data in line blanking", a_blk, 0);
    chk((sel ? done_cnt_b : done_cnt_a) == done0 + 1, "R11", "frame_done count",
        (sel ? done_cnt_b : done_cnt_a) - done0, 1);
  endtask

  task automatic check_vblank(input int vb);
    int n, bad;
    n = 1; bad = 0;
    forever begin
      rise();
      if (vs_m) break;
      if (hs_m || dat_m != 8'h00) bad++;
      n++;
    end
    chk(n == vb, "R4", "frame blanking length", n, vb);
    chk(bad == 0, "R10", "bus quiet in frame blanking", bad, 0);
  endtask

  task automatic test_pulse_frame();
    sel = 1'b0;
    hold_a = 1'b0;
    @(posedge clk); #1 start_a = 1'b1;
    @(posedge clk); #1 start_a = 1'b0;
    capture(A_PIX, A_LINES, A_HB, 2, 1'b0, 1'b0, "R5");
    check_vblank(A_VB);
  endtask

  task automatic test_mode_switch();
    sel = 1'b0;
    // flip mid-frame: this frame keeps pulse mode (R7)
    capture(A_PIX, A_LINES, A_HB, 2, 1'b0, 1'b1, "R7");
    // next frames use hold mode; counter restarts each frame (R8)
    capture(A_PIX, A_LINES, A_HB, 2, 1'b1, 1'b0, "R7 R6");
    capture(A_PIX, A_LINES, A_HB, 2, 1'b1, 1'b0, "R6");
  endtask

  task automatic test_byte_mode();
    @(posedge clk); #1 start_b = 1'b1;
    @(posedge clk); #1 start_b = 1'b0;
    sel = 1'b1;
    capture(B_PIX, B_LINES, B_HB, 1, 1'b1, 1'b0, "R6");
    sel = 1'b0;
  endtask

  initial begin
    test_reset_idle();
    test_pclk();
    test_pulse_frame();
    test_mode_switch();
    test_byte_mode();
    chk(r2_err == 0, "R2", "bus moved off pclk fall", r2_err, 0);
    chk(wide_done == 0, "R11", "frame_done wider than one cycle", wide_done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule